// File: doc/BRIEF.md
# Configurable Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel samples. Each channel field is a twos-complement word sent most significant bit first, and the left field always comes before the right field in a frame. The serial lines are a bit clock, a word clock, a left/right clock and one data line. All of them are sampled by the block's own system clock, and the block finds the bit-clock edges itself. Three static settings shape the framing: which bit-clock edge samples data, whether the first data bit lags the framing event by one bit, and whether a field starts on a word-clock rising edge or on any left/right clock transition.

A field may carry anywhere from 4 to 20 bits. The block always delivers a 20-bit word with the received bits at the top and zeros below them. Each finished word appears with a single-cycle valid strobe and a flag that marks it as left or right. A word is finished by whichever comes first: the framing event that starts the next field, or the arrival of its 20th bit. The settings are captured while the block waits after reset, so a later change on those pins has no effect until the next reset.

Top module: `sar_rx`

## Requirements
- R1: During and right after reset, `smp_valid` is 0 and `smp_word` is 0.
- R2: With `cfg_fall_edge` at 0, data is sampled on rising edges of `bclk`.
- R3: With `cfg_fall_edge` at 1, data is sampled on falling edges of `bclk`.
- R4: With `cfg_lr_trig` at 1, a rising `lrclk` transition at a sampling edge starts a left field, a falling one starts a right field, and `wclk` has no effect.
- R5: With `cfg_lr_trig` at 0, a field starts at the first sampling edge where `wclk` is 1 after it was 0 at the previous sampling edge. `smp_left` takes the `lrclk` level at that edge (1 = left). Transitions of `lrclk` alone start no field.
- R6: With `cfg_msb_dly` at 1, the bit at the framing edge is dropped and the MSB is taken at the next sampling edge. With 0, the bit at the framing edge is the MSB.
- R7: A field of N bits (N below 20) is delivered with its bits in `smp_word[19:20-N]` and zeros in the remaining low bits.
- R8: A field is delivered as soon as its 20th bit arrives. Any further bits are dropped, and the next framing event does not deliver that field again.
- R9: A field with fewer than 20 bits is delivered when the next framing event arrives, with a `smp_valid` pulse of one cycle. No word is delivered for a field with zero bits, and none before the first framing event after reset.
- R10: A framing event may come straight after the previous field's last bit, and `bclk` may stop between fields without losing or adding words.
- R11: The `cfg_*` inputs are captured after reset, up to the first `bclk` transition. Later changes on them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples every serial line |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock |
| wclk | input | 1 | Word clock; used for framing when `cfg_lr_trig` is 0 |
| lrclk | input | 1 | Left/right clock; HI marks the left channel |
| sdata | input | 1 | Serial data, MSB first |
| cfg_fall_edge | input | 1 | 0: sample on rising bit-clock edges; 1: on falling edges |
| cfg_msb_dly | input | 1 | 1: MSB comes one bit after the framing event |
| cfg_lr_trig | input | 1 | 1: left/right transitions frame fields; 0: word-clock rising edge |
| smp_word | output | 20 | Received word, left-justified and zero-filled |
| smp_valid | output | 1 | One-cycle strobe for `smp_word` |
| smp_left | output | 1 | 1 when `smp_word` belongs to the left channel |

## Verification
The assertions assume that `bclk` holds each level for at least two system-clock cycles. They also assume that `sdata`, `wclk` and `lrclk` change only at least one cycle away from the sampling edge, so that two active edges never fall on neighbouring cycles. The stimulus holds each bit-clock level for three cycles. It changes the serial lines one cycle after the non-sampling edge, which also lets a design that samples on the wrong edge pick up the previous bit. In every scenario the field begins with a preamble bit that is not a framing event, so the first real field starts with a valid previous sample.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // static framing settings, captured after reset
  typedef struct packed {
    logic fall_edge;  // 1: sample on falling bit-clock edge
    logic msb_dly;    // 1: MSB one bit after the framing event
    logic lr_trig;    // 1: left/right transitions frame fields
  } sar_cfg_t;

  // mask of the low bit positions that a field of 'used' bits leaves empty
  // in a word of 'width' bits (left-justified storage)
  function automatic logic [31:0] tail_mask(input int unsigned width,
                                            input int unsigned used);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if ((used <= width) && (i < int'(width - used))) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic wclk,
  input  logic lrclk,
  input  logic sdata,
  input  logic fall_edge,
  output logic strobe,
  output logic any_edge,
  output logic s_wclk,
  output logic s_lr,
  output logic s_data
);

  logic b_now, b_old;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_now  <= 1'b0;
      b_old  <= 1'b0;
      s_wclk <= 1'b0;
      s_lr   <= 1'b0;
      s_data <= 1'b0;
    end else begin
      b_now  <= bclk;
      b_old  <= b_now;
      s_wclk <= wclk;
      s_lr   <= lrclk;
      s_data <= sdata;
    end
  end

  assign any_edge = b_now ^ b_old;
  // active edge: the new level is the one the chosen edge ends on
  assign strobe   = any_edge && (b_now == ~fall_edge);

endmodule

// File: rtl/sar_frame_det.sv
module sar_frame_det (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic s_wclk,
  input  logic s_lr,
  input  logic lr_trig,
  output logic frame_evt,
  output logic evt_left
);

  logic lr_prev, wc_prev, primed;
  logic lr_change, wc_rise;

  assign lr_change = s_lr ^ lr_prev;
  assign wc_rise   = s_wclk & ~wc_prev;
  assign frame_evt = strobe && primed && (lr_trig ? lr_change : wc_rise);
  assign evt_left  = s_lr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_prev <= 1'b0;
      wc_prev <= 1'b0;
      primed  <= 1'b0;
    end else if (strobe) begin
      lr_prev <= s_lr;
      wc_prev <= s_wclk;
      primed  <= 1'b1;
    end
  end

  AST_EVENT_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |-> strobe);  // R2

endmodule

// File: rtl/sar_word_asm.sv
module sar_word_asm #(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              s_data,
  input  logic              frame_evt,
  input  logic              evt_left,
  input  logic              msb_dly,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              left_o
);
  import sar_pkg::*;

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg, ins_word;
  logic [CNT_W-1:0]  bit_cnt, out_cnt;
  logic              active, cur_left;
  logic              field_open;   // field still waiting for bits
  logic [WORD_W-1:0] pad_mask;

  // word with the current bit placed at its left-justified position
  always_comb begin
    ins_word = shreg;
    if (bit_cnt < FULL) ins_word[LAST - bit_cnt] = s_data;
  end

  assign field_open = active && (bit_cnt != '0) && (bit_cnt != FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '0;
      bit_cnt  <= '0;
      active   <= 1'b0;
      cur_left <= 1'b0;
      word_o   <= '0;
      valid_o  <= 1'b0;
      left_o   <= 1'b0;
      out_cnt  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (strobe) begin
        if (frame_evt) begin
          if (field_open) begin
            word_o  <= shreg;
            left_o  <= cur_left;
            out_cnt <= bit_cnt;
            valid_o <= 1'b1;
          end
          active   <= 1'b1;
          cur_left <= evt_left;
          if (msb_dly) begin
            shreg   <= '0;
            bit_cnt <= '0;
          end else begin
            shreg              <= '0;
            shreg[WORD_W-1]    <= s_data;
            bit_cnt            <= CNT_W'(1);
          end
        end else if (active && (bit_cnt < FULL)) begin
          shreg   <= ins_word;
          bit_cnt <= bit_cnt + CNT_W'(1);
          if (bit_cnt == LAST) begin
            word_o  <= ins_word;
            left_o  <= cur_left;
            out_cnt <= FULL;
            valid_o <= 1'b1;
          end
        end
      end
    end
  end

  assign pad_mask = tail_mask(WORD_W, int'(out_cnt))[WORD_W-1:0];

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((word_o & pad_mask) == '0));  // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= FULL);  // R8
  AST_DISCARD_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == FULL) && strobe && !frame_evt |=> (bit_cnt == FULL) && !valid_o);  // R8
  AST_DELAY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt && msb_dly |=> (bit_cnt == '0));  // R6
  AST_EMIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(strobe));  // R9

endmodule

// File: rtl/sar_rx.sv
module sar_rx #(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              wclk,
  input  logic              lrclk,
  input  logic              sdata,
  input  logic              cfg_fall_edge,
  input  logic              cfg_msb_dly,
  input  logic              cfg_lr_trig,
  output logic [WORD_W-1:0] smp_word,
  output logic              smp_valid,
  output logic              smp_left
);
  import sar_pkg::*;

  sar_cfg_t cfg_q;
  logic     armed;
  logic     strobe, any_edge, s_wclk, s_lr, s_data;
  logic     frame_evt, evt_left;

  // settings follow the pins until the first bit-clock transition
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b1;
      cfg_q <= '0;
    end else if (armed) begin
      cfg_q <= '{fall_edge: cfg_fall_edge, msb_dly: cfg_msb_dly, lr_trig: cfg_lr_trig};
      if (any_edge) armed <= 1'b0;
    end
  end

  sar_edge_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk     (bclk),
    .wclk     (wclk),
    .lrclk    (lrclk),
    .sdata    (sdata),
    .fall_edge(cfg_q.fall_edge),
    .strobe   (strobe),
    .any_edge (any_edge),
    .s_wclk   (s_wclk),
    .s_lr     (s_lr),
    .s_data   (s_data)
  );

  sar_frame_det u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .s_wclk   (s_wclk),
    .s_lr     (s_lr),
    .lr_trig  (cfg_q.lr_trig),
    .frame_evt(frame_evt),
    .evt_left (evt_left)
  );

  sar_word_asm #(.WORD_W(WORD_W)) u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .s_data   (s_data),
    .frame_evt(frame_evt),
    .evt_left (evt_left),
    .msb_dly  (cfg_q.msb_dly),
    .word_o   (smp_word),
    .valid_o  (smp_valid),
    .left_o   (smp_left)
  );

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> $stable(cfg_q));  // R11
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);  // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rst_n) |-> !smp_valid);  // R1

endmodule

// File: tb/sar_rx_tb.sv
module sar_rx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, wclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic        cfg_fall_edge = 1'b0, cfg_msb_dly = 1'b0, cfg_lr_trig = 1'b1;
  logic [19:0] smp_word;
  logic        smp_valid, smp_left;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  // waveform settings used by the stimulus (may differ from the cfg pins)
  bit act_fall = 1'b0;
  bit act_dly  = 1'b0;
  bit act_lrt  = 1'b1;

  logic [20:0] got_q[$];
  logic [20:0] exp_q[$];

  always #4 clk = ~clk;  // 125 MHz

  sar_rx dut_i (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk), .lrclk(lrclk),
    .sdata(sdata), .cfg_fall_edge(cfg_fall_edge), .cfg_msb_dly(cfg_msb_dly),
    .cfg_lr_trig(cfg_lr_trig), .smp_word(smp_word), .smp_valid(smp_valid),
    .smp_left(smp_left)
  );

  always @(negedge clk) if (rst_n && smp_valid) got_q.push_back({smp_left, smp_word});

  function automatic logic [19:0] exp_word(input int n, input logic [31:0] v);
    if (n <= 20) return 20'(v << (20 - n));
    return 20'(v >> (n - 20));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_reset(input bit fall, input bit dly, input bit lrt);
    @(negedge clk);
    rst_n = 1'b0;
    act_fall = fall; act_dly = dly; act_lrt = lrt;
    cfg_fall_edge = fall; cfg_msb_dly = dly; cfg_lr_trig = lrt;
    bclk = fall; wclk = 1'b0; lrclk = 1'b0; sdata = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    got_q.delete();
    exp_q.delete();
  endtask

  // one bit: lines change a cycle after the idle edge, then the active edge
  task automatic send_bit(input logic d, input logic lr, input logic wc);
    bclk = act_fall;
    @(negedge clk);
    sdata = d; lrclk = lr; wclk = wc;
    repeat (2) @(negedge clk);
    bclk = ~act_fall;
    repeat (3) @(negedge clk);
  endtask

  // one field; in left/right mode the word clock toggles as noise
  task automatic send_field(input int n, input logic [31:0] v, input logic lr);
    if (act_dly) send_bit(1'b1, lr, act_lrt ? 1'b1 : 1'b1);
    for (int i = 0; i < n; i++) begin
      logic wc;
      if (act_lrt) wc = i[0];
      else wc = (!act_dly && i == 0);
      send_bit(v[n-1-i], lr, wc);
    end
  endtask

  task automatic expect_word(input logic left, input int n, input logic [31:0] v);
    exp_q.push_back({left, exp_word(n, v)});
  endtask

  task automatic compare(input string req);
    repeat (10) @(negedge clk);
    check({req, " word count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size(); i++) begin
      if (i < got_q.size()) check(req, {11'b0, got_q[i]}, {11'b0, exp_q[i]});
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", smp_valid, 0);
    check("R1 word in reset", smp_word, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", smp_valid, 0);
  endtask

  // R2 R4 R9: rising edge, left/right framing, word clock as noise
  task automatic t_lr_basic;
    apply_reset(1'b0, 1'b0, 1'b1);
    send_bit(1'b1, 1'b0, 1'b1);
    send_field(16, 32'hABCD, 1'b1);
    send_field(16, 32'h1234, 1'b0);
    send_field(1, 32'h1, 1'b1);
    expect_word(1'b1, 16, 32'hABCD);
    expect_word(1'b0, 16, 32'h1234);
    compare("R2 R4 R9 lr framing");
  endtask

  // R3 R6 R9: falling edge, delayed MSB, full words, empty fields
  task automatic t_fall_delay;
    apply_reset(1'b1, 1'b1, 1'b1);
    send_bit(1'b0, 1'b0, 1'b0);
    send_field(20, 32'hF00F1, 1'b1);
    send_field(20, 32'h80001, 1'b0);
    send_field(0, 32'h0, 1'b1);
    send_field(0, 32'h0, 1'b0);
    send_field(0, 32'h0, 1'b1);
    expect_word(1'b1, 20, 32'hF00F1);
    expect_word(1'b0, 20, 32'h80001);
    compare("R3 R6 R9 falling delayed");
  endtask

  // R5 R7: word-clock framing, tag from lrclk level, short words
  task automatic t_wc_mode;
    apply_reset(1'b0, 1'b0, 1'b0);
    send_bit(1'b0, 1'b0, 1'b0);
    send_field(4, 32'hA, 1'b1);
    send_field(4, 32'h5, 1'b0);
    send_field(12, 32'h9C3, 1'b1);
    // lrclk toggles without a word-clock edge: still the same field
    send_bit(1'b1, 1'b0, 1'b0);
    send_field(1, 32'h1, 1'b1);
    expect_word(1'b1, 4, 32'hA);
    expect_word(1'b0, 4, 32'h5);
    expect_word(1'b1, 13, 32'h1387);
    compare("R5 R7 word clock");
  endtask

  // R8: oversized field cut at 20 bits, not delivered twice
  task automatic t_long_field;
    apply_reset(1'b0, 1'b0, 1'b1);
    send_bit(1'b0, 1'b0, 1'b0);
    send_field(24, 32'hABCDEF, 1'b1);
    send_field(8, 32'h7E, 1'b0);
    send_field(1, 32'h0, 1'b1);
    expect_word(1'b1, 24, 32'hABCDEF);
    expect_word(1'b0, 8, 32'h7E);
    compare("R8 long field");
  endtask

  // R10: bit clock stopped between fields, then back-to-back fields
  task automatic t_gated_gap;
    apply_reset(1'b0, 1'b1, 1'b1);
    send_bit(1'b0, 1'b0, 1'b0);
    send_field(10, 32'h2A5, 1'b1);
    bclk = act_fall;
    repeat (25) @(negedge clk);
    send_field(6, 32'h2D, 1'b0);
    send_field(5, 32'h13, 1'b1);
    send_field(0, 32'h0, 1'b0);
    expect_word(1'b1, 10, 32'h2A5);
    expect_word(1'b0, 6, 32'h2D);
    expect_word(1'b1, 5, 32'h13);
    compare("R10 gap and back-to-back");
  endtask

  // R11: settings pins change after capture, waveform keeps old settings
  task automatic t_cfg_latch;
    apply_reset(1'b0, 1'b0, 1'b1);
    send_bit(1'b0, 1'b0, 1'b0);
    cfg_fall_edge = 1'b1; cfg_msb_dly = 1'b1; cfg_lr_trig = 1'b0;
    send_field(8, 32'hC5, 1'b1);
    send_field(8, 32'h3A, 1'b0);
    send_field(1, 32'h1, 1'b1);
    expect_word(1'b1, 8, 32'hC5);
    expect_word(1'b0, 8, 32'h3A);
    compare("R11 settings held");
  endtask

  initial begin
    t_reset();
    t_lr_basic();
    t_fall_delay();
    t_wc_mode();
    t_long_field();
    t_gated_gap();
    t_cfg_latch();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule